// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block connects a synchronous single-request host port to a 256K x 16 asynchronous DRAM whose row and column addresses share one 9-bit pin bus. The host presents an 18-bit word address, a read/write flag, two byte enables and write data. It holds the request until `req_ready` is high. The controller opens the addressed row with the row strobe, runs one column cycle and returns read data with a one-cycle valid pulse.

After an access the row stays open. A later request to the same row goes straight to a column cycle. A request to another row first closes the open row and waits out the precharge time. A free-running interval counter schedules refresh, and each refresh lowers both column strobes before the row strobe. A pending refresh wins over new host requests.

Every timing limit is a nanosecond parameter. It is rounded up to whole clock cycles, and a single down-counter holds each phase for that many cycles. The minimums therefore hold for any clock period. The row strobe is never held low longer than a maximum active time, also set by a parameter.

Top module: `fpdram_ctrl`

## Requirements
- R1: After reset, the row strobe, both column strobes, write enable and output enable are high, `dram_dq_oe` and `rd_valid` are low, and `req_ready` is high.
- R2: For request address a, the row is a[17:9] and is on `dram_addr` when the row strobe falls. The column is a[8:0] and is on `dram_addr` when a column strobe falls.
- R3: A read returns the addressed word in a single-cycle `rd_valid` pulse. It is captured at least the column access time (15 ns) after the column strobes fall and at least the row access time (60 ns) after the row strobe falls.
- R4: `req_be[1]` enables the upper strobe, which covers data bits 15:8. `req_be[0]` enables the lower strobe, which covers bits 7:0. Only enabled strobes fall. A masked write leaves the other byte unchanged, and a write with both enables clear changes nothing.
- R5: On a write, write enable is low for at least one cycle before a column strobe falls. Output enable stays high while write enable is low. `dram_dq_oe` is high only while write enable is low.
- R6: Requests to the open row run as column cycles without a new row strobe fall.
- R7: A request to a different row raises the row strobe and keeps it high for at least the precharge time (40 ns) before the new row opens.
- R8: A refresh starts every `REF_CYC` cycles. In a refresh, both column strobes are low for at least 10 ns before the row strobe falls, and write enable and output enable stay high.
- R9: A due refresh closes an open row and runs, even while same-row requests arrive continuously.
- R10: The row strobe is never low for more than `T_RAS_MAX_NS` (rounded down to cycles). When the limit is near, the row is closed even if same-row requests are waiting.
- R11: Each column strobe stays low for at least the column access time. Between column cycles it stays high for at least the column precharge time. Column strobe falls within a row are at least the page cycle time (25 ns) apart. The row strobe stays low for at least the full cycle time minus the precharge time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in the upper 9 bits |
| req_be | input | 2 | Byte enables, bit 1 upper byte |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_hi_n | output | 1 | Upper-byte column strobe, active low |
| dram_cas_lo_n | output | 1 | Lower-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data returned by the memory |

## Verification
A wrong phase state or a short phase counter shows up within one access. A memory model that returns poison bytes before the access times have passed will hand back a bad word at the next `rd_valid`. The same model reports a short strobe pulse when that strobe edge occurs. A wrong row latch or a swapped address split shows up in the model's contents, which are compared word by word against the bench's shadow copy. A broken refresh counter or a broken row-age limit shows up only over thousands of cycles. These faults are caught by counting refreshes against elapsed cycles and by measuring the longest row-strobe low time during a long same-row stream.

// File: rtl/fpdram_ctrl.sv
module fpdram_ctrl #(
  parameter int ROW_W        = 9,
  parameter int COL_W        = 9,
  parameter int CLK_NS       = 4,
  parameter int T_RAC_NS     = 60,
  parameter int T_CAC_NS     = 15,
  parameter int T_PC_NS      = 25,
  parameter int T_RC_NS      = 110,
  parameter int T_RP_NS      = 40,
  parameter int T_CP_NS      = 10,
  parameter int T_CSR_NS     = 10,
  parameter int T_RAS_MAX_NS = 10000,
  parameter int REF_CYC      = 3900
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [1:0]             req_be,
  input  logic [15:0]            req_wdata,
  output logic                   rd_valid,
  output logic [15:0]            rd_data,
  output logic                   dram_ras_n,
  output logic                   dram_cas_hi_n,
  output logic                   dram_cas_lo_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic [15:0]            dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [15:0]            dram_dq_in
);

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int AW         = ROW_W + COL_W;
  localparam int PW         = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int CAS_CYC    = mx(cyc(T_CAC_NS), 1);
  localparam int RCD_CYC    = mx(cyc(T_RAC_NS - T_CAC_NS), 1);
  localparam int CP_CYC     = mx(mx(cyc(T_CP_NS), cyc(T_PC_NS) - CAS_CYC), 1);
  localparam int RP_CYC     = mx(cyc(T_RP_NS), 1);
  localparam int RASMIN_CYC = mx(cyc(T_RC_NS - T_RP_NS), 1);
  localparam int CSR_CYC    = mx(cyc(T_CSR_NS), 1);
  localparam int RASMAX_CYC = T_RAS_MAX_NS / CLK_NS;
  localparam int TXN_CYC    = 2 + CAS_CYC + CP_CYC;
  localparam int LIM_AGE    = RASMAX_CYC - TXN_CYC - 2;
  localparam int CW         = $clog2(mx(RASMAX_CYC, RCD_CYC) + 1) + 1;
  localparam int RW         = $clog2(REF_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RAS, S_COL, S_CAS, S_CPRE, S_OPEN, S_PRE, S_RCAS, S_RRAS
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt, ras_age;
  logic [RW-1:0]    ref_cnt;
  logic             ref_pend;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [1:0]       be_q;
  logic [15:0]      wd_q;

  wire hit       = req_addr[AW-1:COL_W] == row_q;
  wire lim       = ras_age >= CW'(LIM_AGE);
  wire can_close = ras_age >= CW'(RASMIN_CYC);
  wire close_row = lim || (can_close && (ref_pend || (req_valid && !hit)));

  assign req_ready = !ref_pend &&
                     ((st == S_IDLE) || (st == S_OPEN && hit && !lim));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      cnt           <= '0;
      ras_age       <= '0;
      ref_cnt       <= RW'(REF_CYC - 1);
      ref_pend      <= 1'b0;
      row_q         <= '0;
      col_q         <= '0;
      wr_q          <= 1'b0;
      be_q          <= '0;
      wd_q          <= '0;
      rd_valid      <= 1'b0;
      rd_data       <= '0;
      dram_ras_n    <= 1'b1;
      dram_cas_hi_n <= 1'b1;
      dram_cas_lo_n <= 1'b1;
      dram_we_n     <= 1'b1;
      dram_oe_n     <= 1'b1;
      dram_addr     <= '0;
      dram_dq_out   <= '0;
      dram_dq_oe    <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (dram_ras_n)        ras_age <= '0;
      else if (ras_age != '1) ras_age <= ras_age + 1'b1;
      if (cnt != '0) cnt <= cnt - 1'b1;

      case (st)
        S_IDLE:
          if (ref_pend) begin
            ref_pend      <= 1'b0;
            dram_cas_hi_n <= 1'b0;
            dram_cas_lo_n <= 1'b0;
            cnt           <= CW'(CSR_CYC - 1);
            st            <= S_RCAS;
          end else if (req_valid) begin
            row_q      <= req_addr[AW-1:COL_W];
            col_q      <= req_addr[COL_W-1:0];
            wr_q       <= req_write;
            be_q       <= req_be;
            wd_q       <= req_wdata;
            dram_addr  <= PW'(req_addr[AW-1:COL_W]);
            dram_ras_n <= 1'b0;
            cnt        <= CW'(RCD_CYC - 1);
            st         <= S_RAS;
          end
        S_RAS:
          if (cnt == '0) begin
            dram_addr   <= PW'(col_q);
            dram_we_n   <= !wr_q;
            dram_oe_n   <= wr_q;
            dram_dq_oe  <= wr_q;
            dram_dq_out <= wd_q;
            st          <= S_COL;
          end
        S_COL: begin
          dram_cas_hi_n <= !be_q[1];
          dram_cas_lo_n <= !be_q[0];
          cnt           <= CW'(CAS_CYC - 1);
          st            <= S_CAS;
        end
        S_CAS:
          if (cnt == '0) begin
            dram_cas_hi_n <= 1'b1;
            dram_cas_lo_n <= 1'b1;
            dram_we_n     <= 1'b1;
            dram_oe_n     <= 1'b1;
            dram_dq_oe    <= 1'b0;
            if (!wr_q) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
            cnt <= CW'(CP_CYC - 1);
            st  <= S_CPRE;
          end
        S_CPRE:
          if (cnt == '0) st <= S_OPEN;
        S_OPEN:
          if (close_row) begin
            dram_ras_n <= 1'b1;
            cnt        <= CW'(RP_CYC - 1);
            st         <= S_PRE;
          end else if (req_valid && req_ready) begin
            wr_q        <= req_write;
            be_q        <= req_be;
            dram_addr   <= PW'(req_addr[COL_W-1:0]);
            dram_we_n   <= !req_write;
            dram_oe_n   <= req_write;
            dram_dq_oe  <= req_write;
            dram_dq_out <= req_wdata;
            st          <= S_COL;
          end
        S_PRE:
          if (cnt == '0) st <= S_IDLE;
        S_RCAS:
          if (cnt == '0) begin
            dram_ras_n <= 1'b0;
            cnt        <= CW'(RASMIN_CYC - 1);
            st         <= S_RRAS;
          end
        S_RRAS:
          if (cnt == '0) begin
            dram_ras_n    <= 1'b1;
            dram_cas_hi_n <= 1'b1;
            dram_cas_lo_n <= 1'b1;
            cnt           <= CW'(RP_CYC - 1);
            st            <= S_PRE;
          end
        default: st <= S_IDLE;
      endcase

      if (ref_cnt == '0) begin
        ref_cnt  <= RW'(REF_CYC - 1);
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/fpdram_ctrl_chk.sv
module fpdram_ctrl_chk #(
  parameter int CLK_NS       = 4,
  parameter int T_RP_NS      = 40,
  parameter int T_RAS_MAX_NS = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic dram_ras_n,
  input logic dram_cas_hi_n,
  input logic dram_cas_lo_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dram_dq_oe,
  input logic rd_valid
);

  localparam int RP_CYC = (T_RP_NS + CLK_NS - 1) / CLK_NS;
  localparam int MX_CYC = T_RAS_MAX_NS / CLK_NS;
  localparam int CW     = $clog2(MX_CYC + RP_CYC + 2) + 1;

  logic [CW-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= CW'(RP_CYC);
    end else begin
      lo_cnt <= dram_ras_n ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !dram_ras_n ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1);
    end
  end

  a_r5_oe_high_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> dram_oe_n);

  a_r5_dq_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> !dram_we_n);

  a_r5_we_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_we_n && ($fell(dram_cas_hi_n) || $fell(dram_cas_lo_n))) |-> $past(!dram_we_n));

  a_r8_cas_only_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n && !(dram_cas_hi_n && dram_cas_lo_n)) |-> (dram_we_n && dram_oe_n));

  a_r10_ras_max: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (lo_cnt < CW'(MX_CYC)));

  a_r7_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_cnt >= CW'(RP_CYC)));

  a_r3_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

bind fpdram_ctrl fpdram_ctrl_chk #(
  .CLK_NS(CLK_NS), .T_RP_NS(T_RP_NS), .T_RAS_MAX_NS(T_RAS_MAX_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dram_ras_n(dram_ras_n),
  .dram_cas_hi_n(dram_cas_hi_n), .dram_cas_lo_n(dram_cas_lo_n),
  .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
  .dram_dq_oe(dram_dq_oe), .rd_valid(rd_valid)
);

// File: tb/fpdram_ctrl_test.sv
module fpdram_ctrl_test;

  localparam int CLK     = 4;
  localparam int REF     = 1500;
  localparam int MAXNS   = 2000;
  localparam int CAS_B   = (15 + CLK - 1) / CLK;
  localparam int PC_B    = (25 + CLK - 1) / CLK;
  localparam int CP_B    = ((10 + CLK - 1) / CLK > PC_B - CAS_B) ? (10 + CLK - 1) / CLK : PC_B - CAS_B;
  localparam int RP_B    = (40 + CLK - 1) / CLK;
  localparam int RMIN_B  = (70 + CLK - 1) / CLK;
  localparam int CSR_B   = (10 + CLK - 1) / CLK;
  localparam int RMAX_B  = MAXNS / CLK;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [17:0] req_addr = '0;
  logic [1:0] req_be = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rd_valid, ras_n, uc_n, lc_n, we_n, oe_n, dq_oe;
  logic [15:0] rd_data, dq_out, dq_in;
  logic [8:0] addr;

  always #(CLK / 2) clk = ~clk;

  fpdram_ctrl #(.REF_CYC(REF), .T_RAS_MAX_NS(MAXNS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_ras_n(ras_n), .dram_cas_hi_n(uc_n), .dram_cas_lo_n(lc_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(addr),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  int errors = 0, checks = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural memory model
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  logic p_ras = 1, p_uc = 1, p_lc = 1, p_we = 1;
  int ras_lo = 0, ras_hi = 1000, uc_lo = 0, lc_lo = 0, uc_hi = 1000, lc_hi = 1000;
  int since_fall = 1000, n_ref = 0, n_act = 0, max_lo = 0;
  logic [8:0] m_row = '0;
  logic [15:0] cur_word = '0;

  wire rd_ok = !oe_n && we_n && ((ras_lo + 1) * CLK >= 60);
  wire u_ok  = rd_ok && !uc_n && ((uc_lo + 1) * CLK >= 15);
  wire l_ok  = rd_ok && !lc_n && ((lc_lo + 1) * CLK >= 15);
  assign dq_in = {u_ok ? cur_word[15:8] : 8'hEE, l_ok ? cur_word[7:0] : 8'hEE};

  always @(posedge clk) begin
    if (rst_n) begin
      logic fu, fl;
      int key;
      logic [15:0] w;
      fu = p_uc && !uc_n;
      fl = p_lc && !lc_n;
      if (p_ras && !ras_n) begin
        chk(ras_hi >= RP_B, "R7 precharge before row open", ras_hi, RP_B);
        if (!uc_n && !lc_n) begin
          chk(uc_lo >= CSR_B && lc_lo >= CSR_B, "R8 column-before-row setup", uc_lo, CSR_B);
          chk(we_n && oe_n, "R8 write/output enable high in refresh", {we_n, oe_n}, 3);
          n_ref <= n_ref + 1;
        end else begin
          n_act <= n_act + 1;
          m_row <= addr;
        end
      end
      if (!p_ras && ras_n) begin
        chk(ras_lo >= RMIN_B, "R11 row strobe minimum low", ras_lo, RMIN_B);
        chk(ras_lo <= RMAX_B, "R10 row strobe maximum low", ras_lo, RMAX_B);
        if (ras_lo > max_lo) max_lo <= ras_lo;
      end
      if (!p_uc && uc_n) chk(uc_lo >= CAS_B, "R11 upper strobe width", uc_lo, CAS_B);
      if (!p_lc && lc_n) chk(lc_lo >= CAS_B, "R11 lower strobe width", lc_lo, CAS_B);
      if ((fu || fl) && !ras_n) begin
        if (fu) chk(uc_hi >= CP_B, "R11 upper strobe precharge", uc_hi, CP_B);
        if (fl) chk(lc_hi >= CP_B, "R11 lower strobe precharge", lc_hi, CP_B);
        chk(since_fall >= PC_B, "R11 page cycle", since_fall, PC_B);
        key = int'({m_row, addr});
        w = mem.exists(key) ? mem[key] : 16'h0000;
        if (!we_n) begin
          chk(!p_we, "R5 write enable leads strobe", p_we, 0);
          chk(oe_n && dq_oe, "R5 output enable high, data driven", {oe_n, dq_oe}, 3);
          if (fu) w[15:8] = dq_out[15:8];
          if (fl) w[7:0] = dq_out[7:0];
          mem[key] = w;
        end
        cur_word <= w;
        since_fall <= 0;
      end else begin
        since_fall <= since_fall + 1;
      end
      ras_lo <= !ras_n ? ras_lo + 1 : 0;
      ras_hi <= ras_n ? ras_hi + 1 : 0;
      uc_lo  <= !uc_n ? uc_lo + 1 : 0;
      lc_lo  <= !lc_n ? lc_lo + 1 : 0;
      uc_hi  <= uc_n ? uc_hi + 1 : 0;
      lc_hi  <= lc_n ? lc_hi + 1 : 0;
      p_ras <= ras_n; p_uc <= uc_n; p_lc <= lc_n; p_we <= we_n;
      cyc <= cyc + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_req(input logic w, input logic [17:0] a, input logic [1:0] be, input logic [15:0] d);
    req_write = w; req_addr = a; req_be = be; req_wdata = d; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wr(input logic [17:0] a, input logic [1:0] be, input logic [15:0] d);
    logic [15:0] s;
    s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    if (be[1]) s[15:8] = d[15:8];
    if (be[0]) s[7:0] = d[7:0];
    shadow[int'(a)] = s;
    do_req(1'b1, a, be, d);
  endtask

  task automatic rd(input logic [17:0] a, input logic [1:0] be, input string req);
    logic [15:0] e, m;
    e = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    m = {{8{be[1]}}, {8{be[0]}}};
    do_req(1'b0, a, be, 16'h0);
    while (!rd_valid) @(negedge clk);
    chk((rd_data & m) == (e & m), req, int'(rd_data & m), int'(e & m));
    @(negedge clk);
    chk(!rd_valid, "R3 valid is a single pulse", rd_valid, 0);
  endtask

  initial begin
    int rows[4] = '{0, 1, 170, 511};
    int cols[4] = '{0, 3, 256, 511};
    int a0, r0, lo0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ras_n && uc_n && lc_n && we_n && oe_n, "R1 strobes idle after reset",
        {ras_n, uc_n, lc_n, we_n, oe_n}, 31);
    chk(!dq_oe && !rd_valid && req_ready, "R1 idle outputs after reset",
        {dq_oe, rd_valid, req_ready}, 1);

    for (int i = 0; i < 16; i++)
      wr({rows[i / 4][8:0], cols[i % 4][8:0]}, 2'b11, 16'(i * 16'h1357 ^ 16'hA5C3));
    for (int i = 0; i < 16; i++)
      wr({rows[i / 4][8:0], cols[i % 4][8:0]}, 2'(i % 3), 16'(16'h3C00 + i * 16'h0111));
    for (int i = 0; i < 16; i++)
      rd({rows[i / 4][8:0], cols[i % 4][8:0]}, 2'b11, "R4 masked write keeps other byte (R3 read)");
    for (int i = 0; i < 16; i++)
      rd({rows[i / 4][8:0], cols[i % 4][8:0]}, 2'(1 + i % 2), "R4 byte read");

    r0 = n_ref;
    while (n_ref == r0) @(negedge clk);
    a0 = n_act;
    for (int c = 0; c < 8; c++) begin
      wr({9'd77, 9'(c * 5)}, 2'b11, 16'(16'h7700 + c));
      rd({9'd77, 9'(c * 5)}, 2'b11, "R6 page-mode read");
    end
    chk(n_act - a0 == 1, "R6 one row open for the page", n_act - a0, 1);
    rd({9'd78, 9'd0}, 2'b11, "R7 row miss read");
    chk(n_act - a0 == 2, "R7 row miss opens new row", n_act - a0, 2);

    r0 = n_ref;
    lo0 = max_lo;
    for (int c = 0; c < 200; c++) rd({9'd300, 9'(c)}, 2'b01, "R9 stream read");
    chk(n_ref > r0, "R9 refresh runs during a same-row stream", n_ref - r0, 1);
    chk(max_lo >= RMAX_B - 20 && max_lo <= RMAX_B, "R10 row closed near the limit", max_lo, RMAX_B);
    chk(lo0 <= max_lo, "R10 longest low time tracked", lo0, max_lo);

    foreach (shadow[k])
      chk(mem.exists(k) && mem[k] == shadow[k], "R2 address mapping in model", k, k);

    chk(n_ref >= cyc / REF - 1 && n_ref <= cyc / REF, "R8 refresh count", n_ref, cyc / REF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule